// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block sits between a host and one synchronous DRAM device with several banks, each bank holding rows of column words. It takes one burst request at a time and turns it into a clocked command stream on the four command pins, with the address pins multiplexed by step. The bank and row go out with the row-open command, and the starting column goes out with the column command. Once the column command has been issued, data moves one word per clock, with write data taken from a host stream and read data returned on a host stream.

The burst length is fixed once, when reset is released. The block issues a mode-set command that carries the burst length code and the read latency, and every later access uses that length. The length is 1, 2, 4 or 8 words, or a full row. In full-row mode the request carries a word count and the block ends the burst with an explicit terminate command. Each access follows the same steps: row open, wait for the row-to-column delay, column command, data beats, terminate (full-row mode only), precharge, precharge wait, and then a one-cycle done pulse.

The write stream is valid/ready, but the device cannot pause in the middle of a burst. The host must therefore hold `wr_valid` high in every cycle that `wr_ready` is high. A word the host fails to supply is replaced by the previous word. The read stream has no back-pressure: `rd_valid` words must be taken in the cycle they appear. `req_ready` is a plain level that is high only while the block is idle.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset is released, exactly one mode-set command is issued. Its `sd_addr[2:0]` carries the burst code latched from `cfg_blen` in that cycle (000=1, 001=2, 010=4, 011=8, 111=full row; 100 to 110 act as 8), and its `sd_addr[6:4]` carries CAS_LAT. Later changes of `cfg_blen` have no effect until the next reset.
- R2: `req_ready` is high only when idle. An accepted request produces a row-open command in the next cycle, with the bank on `sd_ba` and the row on `sd_addr`.
- R3: The read or write command follows the row-open command by exactly T_RCD cycles, with no-operation commands in between.
- R4: The column command carries the bank on `sd_ba`, the starting column on the low COL_W bits of `sd_addr`, and `sd_addr[10]` low.
- R5: A fixed-length burst moves 2^code words. Word i uses column (start & ~(n-1)) | ((start+i) & (n-1)), so it wraps inside the aligned block.
- R6: A full-row burst moves `req_len` words (0 counts as 1; values above the row size are clamped to the row size). Columns increment modulo the row size. A terminate command is issued in the cycle after the last beat, and a precharge in the cycle after that.
- R7: For a write, `wr_ready` is high for exactly n consecutive cycles. `wr_col` shows the column that the word accepted in that cycle is stored at, and the word is driven on `sd_dq_out` with `sd_dq_oe` high in the next cycle.
- R8: For a fixed-length burst, a precharge is issued in the cycle after the last beat. `done` is a single-cycle pulse that comes after the precharge wait and after the last read word. It appears in the same cycle that `req_ready` returns high.
- R9: Read word i appears on `rd_data`/`rd_col` with `rd_valid` exactly CAS_LAT+1+i cycles after the read command, in consecutive cycles.
- R10: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP 0111, row open 0011, read 0101, write 0100, terminate 0110, precharge 0010, mode set 0000. NOP is driven during reset and between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_blen | input | 3 | Burst length code, latched at mode set |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Starting column |
| req_len | input | COL_W+1 | Word count for full-row mode |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write word taken this cycle |
| wr_data | input | DATA_W | Write word |
| wr_col | output | COL_W | Column of the word taken this cycle |
| rd_valid | output | 1 | Read word present |
| rd_data | output | DATA_W | Read word |
| rd_col | output | COL_W | Column of the read word |
| done | output | 1 | One-cycle pulse at access end |
| sd_cs_n | output | 1 | Device chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Device bank select |
| sd_addr | output | ROW_W | Multiplexed device address |
| sd_dq_out | output | DATA_W | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from the device |

## Verification
A corrupt beat counter shows within one burst. The terminate or precharge command moves away from the column command by exactly the error, and the number of `wr_ready` or `rd_valid` cycles changes by the same amount. A wrong column walk shows on `wr_col`/`rd_col` at the first wrapping beat, and with the read data coming from the wrong column of the device model. A miscounted delay timer moves the column command away from T_RCD in the first access. A read pipeline that is off by one shifts the first `rd_valid` by a cycle and pairs each word with a neighbouring column.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_MODE, ST_MWAIT, ST_IDLE, ST_RCD, ST_BURST, ST_PRE, ST_TRP
  } seq_st_e;

  localparam logic [2:0] BL_FULL = 3'b111;
endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_col_walk.sv
module sdram_col_walk #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             step,
  input  logic [COL_W-1:0] wrap_mask,
  output logic [COL_W-1:0] col_cur,
  output logic [COL_W-1:0] col_nxt
);
  logic [COL_W-1:0] inc;

  assign inc = col_cur + 1'b1;

  always_comb begin
    if (start)     col_nxt = start_col;
    else if (step) col_nxt = (col_cur & ~wrap_mask) | (inc & wrap_mask);
    else           col_nxt = col_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_cur <= '0;
    else        col_cur <= col_nxt;
  end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 9,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_v,
  input  logic [COL_W-1:0]  beat_col,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              busy
);
  logic [DEPTH-1:0] v;
  logic [COL_W-1:0] c [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin v[0] <= 1'b0; c[0] <= '0; end
        else        begin v[0] <= beat_v; c[0] <= beat_col; end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin v[k] <= 1'b0; c[k] <= '0; end
        else        begin v[k] <= v[k-1]; c[k] <= c[k-1]; end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; rd_col <= '0;
    end else begin
      rd_valid <= v[DEPTH-1];
      rd_col   <= c[DEPTH-1];
      if (v[DEPTH-1]) rd_data <= dq_in;
    end
  end

  assign busy = |v;
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 2,
  parameter int T_MRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_blen,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [COL_W:0]    req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [COL_W-1:0]  wr_col,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int LEN_W     = COL_W + 1;
  localparam int ROW_WORDS = 1 << COL_W;
  localparam int TMR_W     = $clog2(T_RCD + T_RP + T_MRD + 1);

  seq_st_e           st;
  sd_cmd_e           cmd_q;
  logic [BANK_W-1:0] ba_q, bank_q;
  logic [ROW_W-1:0]  addr_q, mode_word;
  logic [2:0]        code_q;
  logic              op_wr;
  logic [COL_W-1:0]  scol_q;
  logic [LEN_W-1:0]  len_q, len_eff, fixed_n, burst_n, left;
  logic              beat_act, done_q, oe_q;
  logic [DATA_W-1:0] dq_q;
  logic              full_pg;
  logic [1:0]        bl_log;
  logic [COL_W-1:0]  wrap_mask, col_cur, col_nxt;
  logic              col_start, col_step;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              rd_busy;

  // burst geometry from the latched mode code
  assign full_pg   = (code_q == BL_FULL);
  assign bl_log    = code_q[2] ? 2'd3 : code_q[1:0];
  assign fixed_n   = LEN_W'(1) << bl_log;
  assign len_eff   = (len_q == '0) ? LEN_W'(1) :
                     (len_q > LEN_W'(ROW_WORDS)) ? LEN_W'(ROW_WORDS) : len_q;
  assign burst_n   = full_pg ? len_eff : fixed_n;
  assign wrap_mask = full_pg ? '1 : COL_W'(fixed_n - 1'b1);

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = cfg_blen;
    mode_word[6:4] = 3'(CAS_LAT);
  end

  assign col_start = (st == ST_RCD) && tmr_zero;
  assign col_step  = (st == ST_BURST) && (left != '0);
  assign wr_ready  = op_wr && (col_start || col_step);
  assign wr_col    = col_nxt;
  assign req_ready = (st == ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_MODE:  begin tmr_load = 1'b1; tmr_val = TMR_W'(T_MRD - 1); end
      ST_IDLE:  if (req_valid) begin tmr_load = 1'b1; tmr_val = TMR_W'(T_RCD - 1); end
      ST_BURST: if (left == '0 && !full_pg) begin tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1); end
      ST_PRE:   begin tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1); end
      default:  ;
    endcase
  end

  sdram_wait_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdram_col_walk #(.COL_W(COL_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(col_start), .start_col(scol_q),
    .step(col_step), .wrap_mask(wrap_mask), .col_cur(col_cur), .col_nxt(col_nxt)
  );

  sdram_rd_pipe #(.DATA_W(DATA_W), .COL_W(COL_W), .DEPTH(CAS_LAT)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .beat_v(beat_act && !op_wr), .beat_col(col_cur),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col),
    .busy(rd_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_MODE; cmd_q <= CMD_NOP; ba_q <= '0; addr_q <= '0;
      code_q <= '0; op_wr <= 1'b0; bank_q <= '0; scol_q <= '0;
      len_q <= '0; left <= '0; beat_act <= 1'b0; done_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      done_q <= 1'b0;
      case (st)
        ST_MODE: begin
          cmd_q <= CMD_MRS; ba_q <= '0; addr_q <= mode_word;
          code_q <= cfg_blen; st <= ST_MWAIT;
        end
        ST_MWAIT: if (tmr_zero) st <= ST_IDLE;
        ST_IDLE: if (req_valid) begin
          op_wr <= req_write; bank_q <= req_bank; scol_q <= req_col;
          len_q <= req_len;
          cmd_q <= CMD_ACT; ba_q <= req_bank; addr_q <= req_row;
          st <= ST_RCD;
        end
        ST_RCD: if (tmr_zero) begin
          cmd_q <= op_wr ? CMD_WR : CMD_RD;
          ba_q <= bank_q; addr_q <= ROW_W'(scol_q);
          left <= burst_n - 1'b1; beat_act <= 1'b1; st <= ST_BURST;
        end
        ST_BURST: begin
          if (left != '0) left <= left - 1'b1;
          else begin
            beat_act <= 1'b0;
            if (full_pg) begin
              cmd_q <= CMD_BST; st <= ST_PRE;
            end else begin
              cmd_q <= CMD_PRE; addr_q <= '0; st <= ST_TRP;
            end
          end
        end
        ST_PRE: begin
          cmd_q <= CMD_PRE; addr_q <= '0; st <= ST_TRP;
        end
        ST_TRP: if (tmr_zero && !rd_busy) begin
          done_q <= 1'b1; st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0; dq_q <= '0;
    end else begin
      oe_q <= wr_ready;
      if (wr_ready && wr_valid) dq_q <= wr_data;
    end
  end

  assign sd_cs_n   = cmd_q[3];
  assign sd_ras_n  = cmd_q[2];
  assign sd_cas_n  = cmd_q[1];
  assign sd_we_n   = cmd_q[0];
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign done      = done_q;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic wr_ready,
  input logic rd_valid,
  input logic done,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_dq_oe
);
  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R2: a row open only follows an accepted request
  p_act_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> $past(req_valid && req_ready));

  // R3: the cycle after a row open is a no-operation
  if (T_RCD > 1) begin : g_gap
    p_act_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |=> (cmd == CMD_NOP));
  end

  // R7: an accepted write word is driven next cycle
  p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> sd_dq_oe);

  // R7: data is driven only with a write or a NOP on the command pins
  p_oe_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == CMD_WR || cmd == CMD_NOP));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done coincides with the return to idle
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R9: read words never overlap a driven bus
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sd_dq_oe);
endmodule

bind sdram_burst_seq sdram_seq_chk #(.T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .done(done),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
  import sdram_seq_pkg::*;

  localparam int T_RCD = 2;
  localparam int CL    = 2;
  localparam int T_MRD = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, wr_valid, wr_ready;
  logic        rd_valid, done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [2:0]  cfg_blen;
  logic [1:0]  req_bank, sd_ba;
  logic [11:0] req_row, sd_addr;
  logic [8:0]  req_col, wr_col, rd_col;
  logic [9:0]  req_len;
  logic [15:0] wr_data, rd_data, sd_dq_out, sd_dq_in;

  sdram_burst_seq #(.T_RCD(T_RCD), .CAS_LAT(CL), .T_MRD(T_MRD)) u_sdram_burst_seq (.*);

  int errs = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int key(input int ba, input int row, input int col);
    return (ba << 21) | (row << 9) | (col & 511);
  endfunction
  function automatic logic [15:0] pat(input int k);
    return k[15:0] ^ 16'h5A5A;
  endfunction
  function automatic int ecol(input int s, input int i, input int n, input bit full);
    if (full) return (s + i) % 512;
    return (s & ~(n - 1)) | ((s + i) & (n - 1));
  endfunction

  // device model and port monitor
  logic [15:0] mem [int];
  logic [15:0] exp_mem [int];
  logic [15:0] hist [16];
  logic [11:0] open_row [4];
  bit dev_act, dev_wr, dev_full;
  int dev_i, dev_bl = 1, dev_ba, dev_col;
  int act_cyc, col_cyc, bst_cyc, pre_cyc, done_cyc, done_cnt, mrs_cnt;
  int act_ba, act_row, col_addr, col_cmd, mrs_addr;
  int nrd, nwr, rd_first, rd_last, wr_last;
  bit rd_gap, wr_gap;
  int rcol [16];
  logic [15:0] rdat [16];
  int wcol [16];
  logic [15:0] wseed;

  always @(negedge clk) begin
    logic [3:0] c;
    int k;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      dev_act = 0;
      sd_dq_in = '0;
    end else begin
      case (c)
        CMD_MRS: begin
          mrs_cnt++; mrs_addr = int'(sd_addr);
          dev_full = (sd_addr[2:0] == 3'b111);
          dev_bl = sd_addr[2] ? 8 : (1 << sd_addr[1:0]);
        end
        CMD_ACT: begin
          open_row[sd_ba] = sd_addr; act_cyc = cyc;
          act_ba = int'(sd_ba); act_row = int'(sd_addr);
        end
        CMD_RD, CMD_WR: begin
          dev_act = 1; dev_wr = (c == CMD_WR); dev_ba = int'(sd_ba);
          dev_col = int'(sd_addr[8:0]); dev_i = 0; col_cyc = cyc;
          col_cmd = int'(c); col_addr = int'(sd_addr);
        end
        CMD_BST: begin dev_act = 0; bst_cyc = cyc; end
        CMD_PRE: begin dev_act = 0; pre_cyc = cyc; end
        default: if (dev_act) begin
          dev_i++;
          if (!dev_full && dev_i == dev_bl) dev_act = 0;
        end
      endcase
      hist[cyc % 16] = 16'hDEAD;
      if (dev_act) begin
        k = key(dev_ba, int'(open_row[dev_ba]), ecol(dev_col, dev_i, dev_bl, dev_full));
        if (dev_wr) begin
          if (sd_dq_oe) mem[k] = sd_dq_out;
        end else hist[cyc % 16] = mem.exists(k) ? mem[k] : pat(k);
      end
      sd_dq_in = hist[(cyc + 16 - CL) % 16];
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (rd_valid) begin
        if (nrd > 0 && cyc != rd_last + 1) rd_gap = 1;
        if (nrd == 0) rd_first = cyc;
        rd_last = cyc;
        if (nrd < 16) begin rcol[nrd] = int'(rd_col); rdat[nrd] = rd_data; end
        nrd++;
      end
      if (wr_ready) begin
        if (nwr > 0 && cyc != wr_last + 1) wr_gap = 1;
        wr_last = cyc;
        wr_data = wseed ^ 16'(nwr);
        if (nwr < 16) wcol[nwr] = int'(wr_col);
        nwr++;
      end
    end
  end

  task automatic clear_mon();
    act_cyc = -1; col_cyc = -1; bst_cyc = -1; pre_cyc = -1; done_cyc = -1;
    done_cnt = 0; nrd = 0; nwr = 0; rd_gap = 0; wr_gap = 0; col_cmd = 0;
  endtask

  task automatic do_reset(input logic [2:0] code);
    rst_n = 0; cfg_blen = code; req_valid = 0;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R10 nop in reset",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(CMD_NOP));
    chk(!req_ready && !done && !rd_valid && !sd_dq_oe, "R2 reset outputs quiet",
        int'({req_ready, done, rd_valid, sd_dq_oe}), 0);
    clear_mon(); mrs_cnt = 0; mrs_addr = -1;
    rst_n = 1;
    repeat (T_MRD + 4) @(negedge clk);
    chk(mrs_cnt == 1, "R1 one mode set", mrs_cnt, 1);
    chk(mrs_addr[2:0] == code, "R1 burst code", mrs_addr[2:0], int'(code));
    chk(mrs_addr[6:4] == CL, "R1 latency field", mrs_addr[6:4], CL);
    chk(req_ready == 1, "R2 idle ready", int'(req_ready), 1);
  endtask

  task automatic access(input bit w, input int ba, input int row, input int col,
                        input int len, input int n, input bit full);
    int t;
    int k;
    logic [15:0] e;
    clear_mon();
    wseed = 16'((ba << 12) ^ row ^ (col << 3));
    while (!req_ready) @(negedge clk);
    req_write = w; req_bank = 2'(ba); req_row = 12'(row); req_col = 9'(col);
    req_len = 10'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2 busy after accept", int'(req_ready), 0);
    t = 0;
    while (done_cnt == 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(act_ba == ba && act_row == row, "R2 bank/row on open", (act_ba << 12) | act_row,
        (ba << 12) | row);
    chk(col_cyc - act_cyc == T_RCD, "R3 open-to-column delay", col_cyc - act_cyc, T_RCD);
    chk(col_cmd == int'(w ? CMD_WR : CMD_RD), "R4 column command", col_cmd,
        int'(w ? CMD_WR : CMD_RD));
    chk(col_addr[8:0] == col[8:0] && col_addr[10] == 0, "R4 column address",
        col_addr, col);
    if (w) begin
      chk(nwr == n && !wr_gap, "R7 write beats", nwr, n);
      for (int i = 0; i < n && i < 16; i++) begin
        chk(wcol[i] == ecol(col, i, n, full), "R7 write column", wcol[i], ecol(col, i, n, full));
        exp_mem[key(ba, row, ecol(col, i, n, full))] = wseed ^ 16'(i);
      end
    end else begin
      chk(rd_first - col_cyc == CL + 1, "R9 read latency", rd_first - col_cyc, CL + 1);
      chk(nrd == n && !rd_gap, full ? "R6 read beats" : "R5 read beats", nrd, n);
      for (int i = 0; i < n && i < 16; i++) begin
        k = key(ba, row, ecol(col, i, n, full));
        e = exp_mem.exists(k) ? exp_mem[k] : pat(k);
        chk(rcol[i] == ecol(col, i, n, full), full ? "R6 column walk" : "R5 column walk",
            rcol[i], ecol(col, i, n, full));
        chk(rdat[i] == e, "R9 read data", int'(rdat[i]), int'(e));
      end
      chk(done_cyc > rd_last, "R8 done after last word", done_cyc, rd_last + 1);
    end
    if (full) begin
      chk(bst_cyc == col_cyc + n, "R6 terminate timing", bst_cyc - col_cyc, n);
      chk(pre_cyc == bst_cyc + 1, "R6 precharge after terminate", pre_cyc - bst_cyc, 1);
    end else begin
      chk(pre_cyc == col_cyc + n, "R8 precharge timing", pre_cyc - col_cyc, n);
    end
    chk(done_cnt == 1 && done_cyc > pre_cyc, "R8 single done after precharge", done_cnt, 1);
  endtask

  bit finished = 0;

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog R8: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    wr_valid = 1; wr_data = '0; req_write = 0; req_bank = '0; req_row = '0;
    req_col = '0; req_len = '0; sd_dq_in = '0;
    // length 4
    do_reset(3'b010);
    access(0, 1, 12'h123, 6, 0, 4, 0);
    access(1, 2, 5, 1, 0, 4, 0);
    access(0, 2, 5, 1, 0, 4, 0);
    // length 8, with the configuration input changed after mode set (R1)
    do_reset(3'b011);
    cfg_blen = 3'b000;
    access(0, 0, 7, 13, 0, 8, 0);
    access(1, 3, 12'hABC, 9, 0, 8, 0);
    access(0, 3, 12'hABC, 9, 0, 8, 0);
    // length 1 at the last column
    do_reset(3'b000);
    access(0, 1, 1, 511, 0, 1, 0);
    access(1, 1, 1, 511, 0, 1, 0);
    access(0, 1, 1, 511, 0, 1, 0);
    // full row with wrap across the row end
    do_reset(3'b111);
    access(0, 2, 9, 510, 5, 5, 1);
    access(1, 0, 2, 508, 6, 6, 1);
    access(0, 0, 2, 508, 6, 6, 1);
    access(0, 1, 3, 40, 0, 1, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule